// File: doc/BRIEF.md
# Single-Cycle Instruction Control and ALU Operation Decoder

This block turns a 32-bit instruction word into the steering signals of a single-cycle load/store processor that executes word load, word store, register add, subtract, bitwise and, bitwise or, set-if-less-than, branch-if-equal and absolute jump. A first decode stage looks only at the six-bit major opcode. It produces the datapath selects: destination-register choice, second-operand choice, writeback-source choice, register write enable, memory read and write strobes, branch and jump flags, and a two-bit ALU class.

A second stage combines that ALU class with the six-bit function field of register-format words to yield a four-bit ALU operation code. A small next-PC helper then forms the taken-branch select from the branch flag and the ALU zero flag, which the surrounding datapath feeds back in the same cycle. It also assembles the absolute jump target from the word's 26-bit index and the top four bits of PC+4.

The whole block is combinational, so every output settles within the cycle in which the instruction is presented. The ALU, register file and memories sit outside it.

Top module: `ctl_decode_top`

## Requirements
- R1: The major opcode sits in instruction bits 31:26. With the controls written as (dst_sel_rd, opb_sel_imm, wb_sel_mem, reg_we, mem_re, mem_we, is_branch, is_jump, alu_class), the decoder drives: opcode 0x00 (register format) → 1,0,0,1,0,0,0,0,10; 0x23 (load) → 0,1,1,1,1,0,0,0,00; 0x2B (store) → 0,1,0,0,0,1,0,0,00; 0x04 (branch-if-equal) → 0,0,0,0,0,0,1,0,01; 0x02 (jump) → 0,0,0,0,0,0,0,1,00.
- R2: Any other opcode drives reg_we, mem_re, mem_we, is_branch, is_jump and every other select to 0, with alu_class 00.
- R3: alu_class 00 produces ALU code 0010 (add), and alu_class 01 produces 0110 (subtract).
- R4: alu_class 10 decodes the function field in bits 5:0. 0x20 gives 0010 (add), 0x22 gives 0110 (subtract), 0x24 gives 0000 (and), 0x25 gives 0001 (or), 0x2A gives 0111 (set-if-less-than) and 0x27 gives 1100 (nor).
- R5: A register-format word whose function field is none of those in R4 gives ALU code 0010.
- R6: For every opcode other than 0x00, the function field has no effect on the ALU code.
- R7: pc_take_branch is 1 exactly when is_branch and alu_zero are both 1. alu_zero has no effect for any non-branch opcode.
- R8: jump_target equals {pc_plus4_hi[3:0], instr[25:0], 2'b00}.
- R9: Store and branch words drive dst_sel_rd and wb_sel_mem to 0. The store strobe and the register write enable are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| pc_plus4_hi | input | 4 | Bits 31:28 of the sequential next PC |
| alu_zero | input | 1 | ALU result-is-zero flag from the datapath |
| dst_sel_rd | output | 1 | 1: write register from bits 15:11; 0: from bits 20:16 |
| opb_sel_imm | output | 1 | 1: ALU operand B is the sign-extended low 16 bits; 0: register read port 2 |
| wb_sel_mem | output | 1 | 1: writeback data from memory; 0: from the ALU |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| is_branch | output | 1 | Conditional branch word |
| is_jump | output | 1 | Absolute jump word |
| alu_class | output | 2 | First-level ALU class (00 add, 01 subtract, 10 use function field) |
| alu_ctl | output | 4 | Final ALU operation code |
| pc_take_branch | output | 1 | PC takes the branch target |
| jump_target | output | 32 | Absolute jump destination |

## Verification
The block holds no state, so a wrong decode term shows at the ports in the same cycle the offending instruction is applied. It appears as a mismatched control bit, an ALU code outside the six legal values, or a write strobe raised alongside a store. Errors in the function-field stage only appear for register-format words. Errors in the branch select only appear when the zero flag and the branch opcode coincide. The stimulus therefore pairs each opcode with disturbing function fields and both zero-flag values.

// File: rtl/ctl_decode_pkg.sv
package ctl_decode_pkg;

    localparam int WORD_W    = 32;
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int JIDX_W    = 26;
    localparam int ALU_CTL_W = 4;
    localparam int CLASS_W   = 2;
    localparam int PC_HI_W   = WORD_W - JIDX_W - 2;
    localparam int OP_LSB    = WORD_W - OP_W;

    // major opcodes
    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    // function field codes for register-format words
    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_NOR = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FIELD = 2'b10,
        CLS_RSVD  = 2'b11
    } alu_class_e;

    typedef enum logic [ALU_CTL_W-1:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_ctl_e;

    typedef struct packed {
        logic       dst_sel_rd;
        logic       opb_sel_imm;
        logic       wb_sel_mem;
        logic       reg_we;
        logic       mem_re;
        logic       mem_we;
        logic       is_branch;
        logic       is_jump;
        alu_class_e alu_class;
    } ctl_word_t;

    localparam ctl_word_t CTL_IDLE = '{
        dst_sel_rd: 1'b0, opb_sel_imm: 1'b0, wb_sel_mem: 1'b0,
        reg_we: 1'b0, mem_re: 1'b0, mem_we: 1'b0,
        is_branch: 1'b0, is_jump: 1'b0, alu_class: CLS_ADD
    };

    function automatic logic [OP_W-1:0] opcode_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:OP_LSB];
    endfunction

    function automatic logic [FN_W-1:0] funct_of(input logic [WORD_W-1:0] w);
        return w[FN_W-1:0];
    endfunction

    function automatic logic [JIDX_W-1:0] jidx_of(input logic [WORD_W-1:0] w);
        return w[JIDX_W-1:0];
    endfunction

    function automatic logic is_legal_alu(input logic [ALU_CTL_W-1:0] c);
        return (c == ALU_AND) || (c == ALU_OR) || (c == ALU_ADD) ||
               (c == ALU_SUB) || (c == ALU_SLT) || (c == ALU_NOR);
    endfunction

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_decode_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_word_t       ctl
);
    always_comb begin
        ctl = CTL_IDLE;
        case (opcode)
            OPC_REG: begin
                ctl.dst_sel_rd = 1'b1;
                ctl.reg_we     = 1'b1;
                ctl.alu_class  = CLS_FIELD;
            end
            OPC_LOAD: begin
                ctl.opb_sel_imm = 1'b1;
                ctl.wb_sel_mem  = 1'b1;
                ctl.reg_we      = 1'b1;
                ctl.mem_re      = 1'b1;
            end
            OPC_STORE: begin
                ctl.opb_sel_imm = 1'b1;
                ctl.mem_we      = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.alu_class = CLS_SUB;
            end
            OPC_JUMP: begin
                ctl.is_jump = 1'b1;
            end
            default: ctl = CTL_IDLE;
        endcase
    end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_decode_pkg::*;
(
    input  alu_class_e            alu_class,
    input  logic [FN_W-1:0]       funct,
    output logic [ALU_CTL_W-1:0]  alu_ctl
);
    alu_ctl_e field_op;

    // second-level decode of the function field
    always_comb begin
        case (funct)
            FN_ADD:  field_op = ALU_ADD;
            FN_SUB:  field_op = ALU_SUB;
            FN_AND:  field_op = ALU_AND;
            FN_OR:   field_op = ALU_OR;
            FN_NOR:  field_op = ALU_NOR;
            FN_SLT:  field_op = ALU_SLT;
            default: field_op = ALU_ADD;
        endcase
    end

    // class bit 1 selects the field decode; bit 0 alone picks subtract
    always_comb begin
        if (alu_class[1])
            alu_ctl = field_op;
        else if (alu_class[0])
            alu_ctl = ALU_SUB;
        else
            alu_ctl = ALU_ADD;
    end
endmodule

// File: rtl/ctl_next_pc.sv
module ctl_next_pc
    import ctl_decode_pkg::*;
(
    input  logic                is_branch,
    input  logic                alu_zero,
    input  logic [PC_HI_W-1:0]  pc_plus4_hi,
    input  logic [JIDX_W-1:0]   jidx,
    output logic                pc_take_branch,
    output logic [WORD_W-1:0]   jump_target
);
    assign pc_take_branch = is_branch & alu_zero;
    assign jump_target    = {pc_plus4_hi, jidx, 2'b00};
endmodule

// File: rtl/ctl_decode_top.sv
module ctl_decode_top
    import ctl_decode_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [3:0]  pc_plus4_hi,
    input  logic        alu_zero,
    output logic        dst_sel_rd,
    output logic        opb_sel_imm,
    output logic        wb_sel_mem,
    output logic        reg_we,
    output logic        mem_re,
    output logic        mem_we,
    output logic        is_branch,
    output logic        is_jump,
    output logic [1:0]  alu_class,
    output logic [3:0]  alu_ctl,
    output logic        pc_take_branch,
    output logic [31:0] jump_target
);
    ctl_word_t ctl;

    ctl_main_dec u_main (
        .opcode (opcode_of(instr)),
        .ctl    (ctl)
    );

    ctl_alu_dec u_alu (
        .alu_class (ctl.alu_class),
        .funct     (funct_of(instr)),
        .alu_ctl   (alu_ctl)
    );

    ctl_next_pc u_npc (
        .is_branch      (ctl.is_branch),
        .alu_zero       (alu_zero),
        .pc_plus4_hi    (pc_plus4_hi),
        .jidx           (jidx_of(instr)),
        .pc_take_branch (pc_take_branch),
        .jump_target    (jump_target)
    );

    assign dst_sel_rd  = ctl.dst_sel_rd;
    assign opb_sel_imm = ctl.opb_sel_imm;
    assign wb_sel_mem  = ctl.wb_sel_mem;
    assign reg_we      = ctl.reg_we;
    assign mem_re      = ctl.mem_re;
    assign mem_we      = ctl.mem_we;
    assign is_branch   = ctl.is_branch;
    assign is_jump     = ctl.is_jump;
    assign alu_class   = ctl.alu_class;
endmodule

// File: rtl/ctl_decode_chk.sv
module ctl_decode_chk
    import ctl_decode_pkg::*;
(
    input logic [31:0] instr,
    input logic [3:0]  pc_plus4_hi,
    input logic        alu_zero,
    input logic        dst_sel_rd,
    input logic        opb_sel_imm,
    input logic        wb_sel_mem,
    input logic        reg_we,
    input logic        mem_re,
    input logic        mem_we,
    input logic        is_branch,
    input logic        is_jump,
    input logic [1:0]  alu_class,
    input logic [3:0]  alu_ctl,
    input logic        pc_take_branch,
    input logic [31:0] jump_target
);
    logic [OP_W-1:0] op;
    logic            op_known;

    assign op       = instr[31:26];
    assign op_known = (op == OPC_REG) || (op == OPC_LOAD) || (op == OPC_STORE) ||
                      (op == OPC_BEQ) || (op == OPC_JUMP);

    always_comb begin
        AST_UNKNOWN_QUIET: assert (op_known || !(reg_we || mem_re || mem_we || is_branch || is_jump)) else $error("unknown opcode not quiet"); // R2
        AST_MEM_EXCL: assert (!(mem_re && mem_we)) else $error("read and write strobes together"); // R1
        AST_RD_SEL_REG_ONLY: assert (!dst_sel_rd || (op == OPC_REG && alu_class == 2'b10 && !opb_sel_imm)) else $error("rd select outside register format"); // R1
        AST_WB_MEM_LOAD: assert (!wb_sel_mem || (mem_re && opb_sel_imm && reg_we)) else $error("memory writeback without load"); // R1
        AST_BRANCH_SUB: assert (!is_branch || (alu_class == 2'b01 && alu_ctl == 4'b0110)) else $error("branch not subtracting"); // R3
        AST_ALU_LEGAL: assert (is_legal_alu(alu_ctl)) else $error("illegal ALU code"); // R4
        AST_NONREG_ADD: assert (op == OPC_REG || op == OPC_BEQ || alu_ctl == 4'b0010) else $error("function field leaked"); // R6
        AST_TAKE_NEEDS_ZERO: assert (!pc_take_branch || (is_branch && alu_zero)) else $error("branch taken without zero"); // R7
        AST_JUMP_QUIET: assert (!is_jump || !(reg_we || mem_we || is_branch)) else $error("jump with side effects"); // R1
        AST_JTGT_FIELDS: assert (jump_target[31:28] == pc_plus4_hi && jump_target[27:2] == instr[25:0] && jump_target[1:0] == 2'b00) else $error("jump target fields"); // R8
        AST_STORE_NO_WB: assert (!(mem_we && reg_we)) else $error("store writes a register"); // R9
    end
endmodule

bind ctl_decode_top ctl_decode_chk chk_i (.*);

// File: tb/ctl_decode_top_tb.sv
module ctl_decode_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] instr;
    logic [3:0]  pc_plus4_hi;
    logic        alu_zero;
    logic        dst_sel_rd, opb_sel_imm, wb_sel_mem, reg_we, mem_re, mem_we;
    logic        is_branch, is_jump, pc_take_branch;
    logic [1:0]  alu_class;
    logic [3:0]  alu_ctl;
    logic [31:0] jump_target;

    ctl_decode_top dut_i (
        .instr(instr), .pc_plus4_hi(pc_plus4_hi), .alu_zero(alu_zero),
        .dst_sel_rd(dst_sel_rd), .opb_sel_imm(opb_sel_imm), .wb_sel_mem(wb_sel_mem),
        .reg_we(reg_we), .mem_re(mem_re), .mem_we(mem_we),
        .is_branch(is_branch), .is_jump(is_jump), .alu_class(alu_class),
        .alu_ctl(alu_ctl), .pc_take_branch(pc_take_branch), .jump_target(jump_target)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // {opcode, funct, ctl10, alu4}; ctl10 = dst,opb,wb,rwe,mre,mwe,br,jmp,class[1:0]
    localparam logic [25:0] VEC [NVEC] = '{
        {6'h00, 6'h20, 10'b1001000010, 4'b0010},
        {6'h00, 6'h22, 10'b1001000010, 4'b0110},
        {6'h00, 6'h24, 10'b1001000010, 4'b0000},
        {6'h00, 6'h25, 10'b1001000010, 4'b0001},
        {6'h00, 6'h2A, 10'b1001000010, 4'b0111},
        {6'h00, 6'h27, 10'b1001000010, 4'b1100},
        {6'h00, 6'h3F, 10'b1001000010, 4'b0010},
        {6'h23, 6'h22, 10'b0111100000, 4'b0010},
        {6'h2B, 6'h24, 10'b0100010000, 4'b0010},
        {6'h04, 6'h20, 10'b0000001001, 4'b0110},
        {6'h02, 6'h2A, 10'b0000000100, 4'b0010},
        {6'h08, 6'h22, 10'b0000000000, 4'b0010},
        {6'h3F, 6'h25, 10'b0000000000, 4'b0010},
        {6'h23, 6'h2A, 10'b0111100000, 4'b0010},
        {6'h2B, 6'h22, 10'b0100010000, 4'b0010}
    };
    localparam string TAG [NVEC] = '{
        "R1 R4", "R1 R4", "R1 R4", "R1 R4", "R1 R4", "R1 R4", "R5",
        "R1 R3 R6", "R1 R3 R6 R9", "R1 R3 R6 R9", "R1 R6",
        "R2 R6", "R2 R6", "R6", "R6 R9"
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [9:0] ctl_now();
        return {dst_sel_rd, opb_sel_imm, wb_sel_mem, reg_we, mem_re, mem_we,
                is_branch, is_jump, alu_class};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [3:0] hi, input logic z);
        @(posedge clk);
        instr       = w;
        pc_plus4_hi = hi;
        alu_zero    = z;
        @(negedge clk);
    endtask

    initial begin
        instr = 32'h0; pc_plus4_hi = 4'h0; alu_zero = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // idle word 0: register format, unknown function field 0x00
        chk("R1 R5", "idle ctl", {22'd0, ctl_now()}, {22'd0, 10'b1001000010});
        chk("R5", "idle alu", {28'd0, alu_ctl}, 32'h2);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] w;
            w = {VEC[i][25:20], 5'd3, 5'd7, 5'd9, 5'd0, VEC[i][19:14]};
            apply(w, 4'h5, 1'b0);
            chk(TAG[i], "ctl", {22'd0, ctl_now()}, {22'd0, VEC[i][13:4]});
            chk(TAG[i], "alu", {28'd0, alu_ctl}, {28'd0, VEC[i][3:0]});
        end

        // R7: taken-branch select
        apply({6'h04, 26'h0012345}, 4'h1, 1'b1);
        chk("R7", "beq zero=1", {31'd0, pc_take_branch}, 32'd1);
        apply({6'h04, 26'h0012345}, 4'h1, 1'b0);
        chk("R7", "beq zero=0", {31'd0, pc_take_branch}, 32'd0);
        apply({6'h00, 20'h0, 6'h22}, 4'h1, 1'b1);
        chk("R7", "reg zero=1", {31'd0, pc_take_branch}, 32'd0);
        apply({6'h02, 26'h0000010}, 4'h1, 1'b1);
        chk("R7", "jump zero=1", {31'd0, pc_take_branch}, 32'd0);
        apply({6'h23, 26'h0000010}, 4'h1, 1'b1);
        chk("R7", "load zero=1", {31'd0, pc_take_branch}, 32'd0);

        // R8: jump target assembly
        apply({6'h02, 26'h3FFFFFF}, 4'hA, 1'b0);
        chk("R8", "jt all ones", jump_target, 32'hAFFFFFFC);
        apply({6'h02, 26'h0000001}, 4'h1, 1'b0);
        chk("R8", "jt one", jump_target, 32'h10000004);
        apply({6'h02, 26'h2AAAAAA}, 4'h0, 1'b0);
        chk("R8", "jt pattern", jump_target, 32'h0AAAAAA8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule